// File: doc/BRIEF.md
# Branch Condition and Loop-Count Unit

This unit decides, for each conditional branch a CPU core issues, whether the branch is taken. It also produces the register write-back and the condition flags that go with that decision. A request carries an operation code, a flag register with a bit index, two register values and a branch target. One clock later the unit returns the taken decision and the target unchanged. When the operation calls for it, the result also carries a write-back value with its enable and new carry, zero and negative flags. Program-counter sequencing and instruction fetch belong to the surrounding core.

There are three groups of operations. The flag-test pair selects one bit of the flag register by index and branches on it being clear or set. The loop-count pair tests one register against zero. On the path where the branch is not taken it hands back that register minus one, so a counting loop needs a single instruction per iteration. The two-register group compares two values without sign for equal, not equal, greater-than and greater-or-equal. Less-than and less-or-equal are obtained by issuing greater-than or greater-or-equal with the operands exchanged.

Top module: `brcond_unit`

## Requirements
- R1: While reset is applied, and until the first request after it, res_valid, res_taken, res_wb_en and res_flag_we are all 0.
- R2: A request with req_valid=1 produces its result with res_valid=1 exactly one clock later, and res_target equals that request's req_target. A cycle without a request gives res_valid, res_taken, res_wb_en and res_flag_we all 0 in the following cycle.
- R3: Op code 0 is taken when req_flags[req_flag_sel] is 0. Op code 1 is taken when that bit is 1. Neither writes back, and neither raises res_flag_we.
- R4: Op code 2 is taken when req_src_a is zero. Otherwise it is not taken and writes back req_src_a minus 1.
- R5: Op code 3 is taken when req_src_a is nonzero. Otherwise it is not taken and writes back 0 minus 1, which wraps to all ones.
- R6: res_wb_en is 1 only for op codes 2 and 3, and only on their not-taken path.
- R7: Op codes 4, 5, 6 and 7 branch when, respectively, req_src_a equals req_src_b, differs from it, is greater than it, or is greater than or equal to it. All four compare without sign.
- R8: Op codes 2 to 7 raise res_flag_we and report the subtraction a minus b: C is its borrow, Z is a equal to b, and N is bit DATA_W-1 of the difference. For op codes 2 and 3, b is taken as zero.
- R9: Issuing op code 6 or 7 with the operands exchanged gives a less-than or a less-or-equal branch.
- R10: req_flag_sel selects any bit from 0 to FLAG_W-1, including the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the unit |
| req_valid | input | 1 | A branch request is present this cycle |
| req_op | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| req_flag_sel | input | SEL_W (3) | Index of the flag bit tested by op codes 0 and 1 |
| req_flags | input | FLAG_W (8) | Current flag register |
| req_src_a | input | DATA_W (16) | First register operand, and the loop counter for op codes 2 and 3 |
| req_src_b | input | DATA_W (16) | Second register operand |
| req_target | input | ADDR_W (16) | Branch target address |
| res_valid | output | 1 | A result is present this cycle |
| res_taken | output | 1 | The branch is taken |
| res_target | output | ADDR_W (16) | Target address of the request |
| res_wb_en | output | 1 | Write res_wb_data back to the counter register |
| res_wb_data | output | DATA_W (16) | Decremented counter value |
| res_flag_we | output | 1 | Update the C, Z and N flags |
| res_c | output | 1 | Borrow of a minus b |
| res_z | output | 1 | a equals b |
| res_n | output | 1 | Top bit of a minus b |

## Verification
The assertions assume that every request field is stable and defined in a cycle where req_valid is 1. They also assume that req_flag_sel never exceeds FLAG_W-1, so the flag index always names a real bit. The stimulus changes inputs only one time unit after a rising edge. It holds each request for exactly one cycle and uses flag indices from 0 up to the top bit. Operand patterns cover zero, one, all ones, equal values and values on both sides of the comparison. Some cases have the top bit set in only one operand, so that N and C disagree.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  typedef enum logic [2:0] {
    OP_FLAG_CLR = 3'd0,
    OP_FLAG_SET = 3'd1,
    OP_DEC_Z    = 3'd2,
    OP_DEC_NZ   = 3'd3,
    OP_CMP_EQ   = 3'd4,
    OP_CMP_NE   = 3'd5,
    OP_CMP_GT   = 3'd6,
    OP_CMP_GE   = 3'd7
  } br_op_e;

  typedef struct packed {
    logic taken;
    logic wb_en;
    logic flag_we;
    logic c;
    logic z;
    logic n;
  } br_verdict_t;

endpackage

// File: rtl/brcond_flag_mux.sv
module brcond_flag_mux #(
  parameter int FLAG_W = 8,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_out
);

  logic [FLAG_W-1:0] hit;

  // one AND term per flag position, reduced by an OR tree
  for (genvar i = 0; i < FLAG_W; i++) begin : g_hit
    assign hit[i] = flags[i] & (sel == SEL_W'(i));
  end

  assign bit_out = |hit;

endmodule

// File: rtl/brcond_cmp.sv
module brcond_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              borrow,
  output logic              equal,
  output logic              diff_msb
);

  logic [DATA_W:0] wide_diff;

  assign wide_diff = {1'b0, a} - {1'b0, b};
  assign borrow    = wide_diff[DATA_W];
  assign equal     = (a == b);
  assign diff_msb  = wide_diff[DATA_W-1];

endmodule

// File: rtl/brcond_decide.sv
module brcond_decide
  import brcond_pkg::*;
(
  input  logic [2:0]  op,
  input  logic        flag_bit,
  input  logic        borrow,
  input  logic        equal,
  input  logic        diff_msb,
  output br_verdict_t verdict
);

  always_comb begin
    verdict         = '0;
    verdict.c       = borrow;
    verdict.z       = equal;
    verdict.n       = diff_msb;
    verdict.flag_we = 1'b1;
    unique case (br_op_e'(op))
      OP_FLAG_CLR: begin
        verdict.taken   = ~flag_bit;
        verdict.flag_we = 1'b0;
      end
      OP_FLAG_SET: begin
        verdict.taken   = flag_bit;
        verdict.flag_we = 1'b0;
      end
      OP_DEC_Z: begin
        verdict.taken = equal;
        verdict.wb_en = ~equal;
      end
      OP_DEC_NZ: begin
        verdict.taken = ~equal;
        verdict.wb_en = equal;
      end
      OP_CMP_EQ: verdict.taken = equal;
      OP_CMP_NE: verdict.taken = ~equal;
      OP_CMP_GT: verdict.taken = ~borrow & ~equal;
      OP_CMP_GE: verdict.taken = ~borrow;
      default:   verdict.taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 8,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [SEL_W-1:0]  req_flag_sel,
  input  logic [FLAG_W-1:0] req_flags,
  input  logic [DATA_W-1:0] req_src_a,
  input  logic [DATA_W-1:0] req_src_b,
  input  logic [ADDR_W-1:0] req_target,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_target,
  output logic              res_wb_en,
  output logic [DATA_W-1:0] res_wb_data,
  output logic              res_flag_we,
  output logic              res_c,
  output logic              res_z,
  output logic              res_n
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // decision datapath
  logic              is_dec;
  logic [DATA_W-1:0] cmp_b;
  logic              sel_bit, borrow, equal, diff_msb;
  br_verdict_t       verdict;

  assign is_dec = (req_op == OP_DEC_Z) || (req_op == OP_DEC_NZ);
  assign cmp_b  = is_dec ? '0 : req_src_b;

  brcond_flag_mux #(.FLAG_W(FLAG_W)) u_flag_mux (
    .flags   (req_flags),
    .sel     (req_flag_sel),
    .bit_out (sel_bit)
  );

  brcond_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a        (req_src_a),
    .b        (cmp_b),
    .borrow   (borrow),
    .equal    (equal),
    .diff_msb (diff_msb)
  );

  brcond_decide u_decide (
    .op       (req_op),
    .flag_bit (sel_bit),
    .borrow   (borrow),
    .equal    (equal),
    .diff_msb (diff_msb),
    .verdict  (verdict)
  );

  // next state
  logic              valid_d, taken_d, wb_en_d, flag_we_d;
  logic              c_d, z_d, n_d;
  logic [ADDR_W-1:0] target_d;
  logic [DATA_W-1:0] wb_data_d;
  logic              data_ce, flag_ce;

  assign data_ce = req_valid;
  assign flag_ce = req_valid & verdict.flag_we;

  always_comb begin
    valid_d   = req_valid;
    taken_d   = req_valid & verdict.taken;
    wb_en_d   = req_valid & verdict.wb_en;
    flag_we_d = flag_ce;
    target_d  = res_target;
    wb_data_d = res_wb_data;
    c_d       = res_c;
    z_d       = res_z;
    n_d       = res_n;
    if (data_ce) begin
      target_d  = req_target;
      wb_data_d = req_src_a - DATA_W'(1);
    end
    if (flag_ce) begin
      c_d = verdict.c;
      z_d = verdict.z;
      n_d = verdict.n;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_wb_en   <= 1'b0;
      res_flag_we <= 1'b0;
      res_target  <= '0;
      res_wb_data <= '0;
      res_c       <= 1'b0;
      res_z       <= 1'b0;
      res_n       <= 1'b0;
    end else begin
      res_valid   <= valid_d;
      res_taken   <= taken_d;
      res_wb_en   <= wb_en_d;
      res_flag_we <= flag_we_d;
      res_target  <= target_d;
      res_wb_data <= wb_data_d;
      res_c       <= c_d;
      res_z       <= z_d;
      res_n       <= n_d;
    end
  end

  // assertions
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_valid |-> (!res_taken && !res_wb_en && !res_flag_we));

  p_target_pass_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> (res_target == $past(req_target)));

  p_flag_test_no_update_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && ($past(req_op) <= 3'd1)) |-> (!res_flag_we && !res_wb_en));

  p_wb_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_wb_en |-> (!res_taken && (($past(req_op) == 3'd2) || ($past(req_op) == 3'd3))));

  p_wb_value_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_wb_en |-> (res_wb_data == $past(req_src_a) - DATA_W'(1)));

  p_gt_order_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_taken && ($past(req_op) == 3'd6)) |-> ($past(req_src_a) > $past(req_src_b)));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_flag_we && ($past(req_op) >= 3'd4)) |-> (res_z == ($past(req_src_a) == $past(req_src_b))));

endmodule

// File: tb/brcond_unit_bench.sv
`timescale 1ns/1ps
module brcond_unit_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 16;
  localparam int FLAG_W = 8;
  localparam int SEL_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [2:0]        req_op = '0;
  logic [SEL_W-1:0]  req_flag_sel = '0;
  logic [FLAG_W-1:0] req_flags = '0;
  logic [DATA_W-1:0] req_src_a = '0;
  logic [DATA_W-1:0] req_src_b = '0;
  logic [ADDR_W-1:0] req_target = '0;
  logic              res_valid, res_taken, res_wb_en, res_flag_we, res_c, res_z, res_n;
  logic [ADDR_W-1:0] res_target;
  logic [DATA_W-1:0] res_wb_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  brcond_unit u_brcond_unit (
    .clk, .rst_n, .req_valid, .req_op, .req_flag_sel, .req_flags,
    .req_src_a, .req_src_b, .req_target,
    .res_valid, .res_taken, .res_target, .res_wb_en, .res_wb_data,
    .res_flag_we, .res_c, .res_z, .res_n
  );

  typedef struct {
    string             tag;
    logic              taken;
    logic              wb_en;
    logic [DATA_W-1:0] wb_data;
    logic              flag_we;
    logic              c, z, n;
    logic [ADDR_W-1:0] target;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: computes the expected result from the requirements and issues the request
  task automatic issue(input string tag, input int op, input int sel, input int flags,
                       input int a, input int b, input int tgt);
    exp_t e;
    int   eb;
    int   fbit;
    e.tag     = tag;
    e.target  = ADDR_W'(tgt);
    e.wb_en   = 1'b0;
    e.wb_data = DATA_W'(a - 1);
    fbit      = (flags >> sel) & 1;
    eb        = (op == 2 || op == 3) ? 0 : b;
    e.flag_we = (op >= 2);
    e.c       = (a < eb);
    e.z       = (a == eb);
    e.n       = ((a - eb) >> (DATA_W - 1)) & 1;
    case (op)
      0: e.taken = (fbit == 0);
      1: e.taken = (fbit == 1);
      2: begin e.taken = (a == 0); e.wb_en = (a != 0); end
      3: begin e.taken = (a != 0); e.wb_en = (a == 0); end
      4: e.taken = (a == b);
      5: e.taken = (a != b);
      6: e.taken = (a > b);
      default: e.taken = (a >= b);
    endcase
    @(posedge clk); #1;
    sb.push_back(e);
    req_valid    = 1'b1;
    req_op       = 3'(op);
    req_flag_sel = SEL_W'(sel);
    req_flags    = FLAG_W'(flags);
    req_src_a    = DATA_W'(a);
    req_src_b    = DATA_W'(b);
    req_target   = ADDR_W'(tgt);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_src_a = 16'h5A5A;
    req_op    = 3'd7;
  endtask

  // monitor: pops the scoreboard when a result shows up
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check("R2", 1'b0, "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, res_taken == e.taken, "taken", res_taken, e.taken);
        check("R2", res_target == e.target, "target", res_target, e.target);
        check("R6", res_wb_en == e.wb_en, "wb_en", res_wb_en, e.wb_en);
        if (e.wb_en)
          check(e.tag, res_wb_data == e.wb_data, "wb_data", res_wb_data, e.wb_data);
        check("R8", res_flag_we == e.flag_we, "flag_we", res_flag_we, e.flag_we);
        if (e.flag_we)
          check("R8", {res_c, res_z, res_n} == {e.c, e.z, e.n}, "czn",
                {res_c, res_z, res_n}, {e.c, e.z, e.n});
      end
    end
  end

  task automatic idle_check();
    @(posedge clk); #1;
    @(negedge clk);
    check("R2", {res_valid, res_taken, res_wb_en, res_flag_we} == 4'b0, "idle strobes",
          {res_valid, res_taken, res_wb_en, res_flag_we}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {res_valid, res_taken, res_wb_en, res_flag_we} == 4'b0, "reset strobes",
          {res_valid, res_taken, res_wb_en, res_flag_we}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", {res_valid, res_taken, res_wb_en, res_flag_we} == 4'b0, "post reset strobes",
          {res_valid, res_taken, res_wb_en, res_flag_we}, 0);

    // R3: flag test clear / set
    issue("R3", 0, 2, 'h04, 0, 0, 'h1000);
    issue("R3", 0, 2, 'hFB, 0, 0, 'h1001);
    issue("R3", 1, 0, 'h01, 0, 0, 'h1002);
    issue("R3", 1, 5, 'hDF, 0, 0, 'h1003);
    // R10: top and bottom flag index
    issue("R10", 1, 7, 'h80, 0, 0, 'h1004);
    issue("R10", 0, 7, 'h7F, 0, 0, 'h1005);
    issue("R10", 0, 0, 'hFE, 0, 0, 'h1006);
    // R4: branch on zero else decrement
    issue("R4", 2, 0, 0, 0, 'h1234, 'h2000);
    issue("R4", 2, 0, 0, 5, 0, 'h2001);
    issue("R4", 2, 0, 0, 'h8000, 'h0001, 'h2002);
    issue("R4", 2, 0, 0, 1, 0, 'h2003);
    // R5: branch on nonzero else decrement to all ones
    issue("R5", 3, 0, 0, 3, 7, 'h3000);
    issue("R5", 3, 0, 0, 0, 7, 'h3001);
    issue("R5", 3, 0, 0, 'hFFFF, 0, 'h3002);
    // R7: unsigned two-register compares
    issue("R7", 4, 0, 0, 'h00AA, 'h00AA, 'h4000);
    issue("R7", 4, 0, 0, 'h00AA, 'h00AB, 'h4001);
    issue("R7", 5, 0, 0, 'h0010, 'h0010, 'h4002);
    issue("R7", 5, 0, 0, 'hFFFF, 'h0000, 'h4003);
    issue("R7", 6, 0, 0, 'h8000, 'h7FFF, 'h4004);
    issue("R7", 6, 0, 0, 'h0100, 'h0100, 'h4005);
    issue("R7", 6, 0, 0, 'h0001, 'hFFFF, 'h4006);
    issue("R7", 7, 0, 0, 'h0100, 'h0100, 'h4007);
    issue("R7", 7, 0, 0, 'h00FF, 'h0100, 'h4008);
    issue("R8", 7, 0, 0, 'h0000, 'h0001, 'h4009);
    // R9: less-than and less-or-equal via swapped operands
    issue("R9", 6, 0, 0, 'h0020, 'h0010, 'h5000);
    issue("R9", 6, 0, 0, 'h0010, 'h0020, 'h5001);
    issue("R9", 7, 0, 0, 'h0010, 'h0010, 'h5002);
    issue("R9", 7, 0, 0, 'h0010, 'h0011, 'h5003);
    // R2: a gap yields quiet strobes
    idle_check();
    issue("R2", 4, 0, 0, 'h0001, 'h0001, 'hFFFF);
    idle_check();

    repeat (4) @(posedge clk);
    check("R2", sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule